// File: doc/BRIEF.md
# Multi-Format PCM Serial Receiver

This block turns three synchronous serial audio data lines into parallel stereo samples. The lines share one bit clock and one frame clock. Both clocks are oversampled by a faster system clock, so the block runs in a single clock domain. Each line carries a left and a right word per frame, most significant bit first and in two's complement. A 3-bit format code picks one of five framings: 16-bit, 20-bit or 24-bit right-aligned to the frame-clock transition, 24-bit left-aligned to it, or 24-bit with a one-bit delay after it.

The effective format code is the bitwise OR of a register field and a set of external strap pins. Short words are placed in the upper bits of the 24-bit output and the low bits are filled with zero, so full scale is the same in every format. The three lanes publish together. When a frame's right word is complete, all six outputs change at once and a single-cycle valid strobe goes high.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted, and after its release until the first valid strobe, every sample output is zero and the valid strobe is low.
- R2: The effective format is `fmt_reg_i | fmt_pin_i`. Codes 000, 001, 010 and 011 select 16-bit right-aligned, 20-bit right-aligned, 24-bit left-aligned and 24-bit one-bit-delayed framing. Any code with bit 2 set selects 24-bit right-aligned framing.
- R3: Data bits are taken on rising edges of the bit clock, most significant bit first, and output in two's complement.
- R4: In the right-aligned modes, the word is the last N bits received before a frame-clock transition (N = 16, 20 or 24), and any earlier bits of that half-frame have no effect. A 16-bit word appears as `{word,8'h00}` and a 20-bit word as `{word,4'h0}`.
- R5: In the left-aligned mode, the MSB is the first bit after the frame-clock transition. The 24 bits from there form the word, and later bits of the half-frame have no effect. 16-bit or 20-bit data padded with zero low bits passes through unchanged.
- R6: In the one-bit-delayed mode, the MSB is the second bit after the transition. Left data is sent while the frame clock is low. A half-frame of exactly 24 bits is allowed, with its LSB on the first bit of the next half.
- R7: In all other modes, left data is sent while the frame clock is high and right data while it is low.
- R8: `valid_o` is a one-cycle pulse raised once per frame, after the right word completes. All three lanes' outputs change only in that cycle and hold otherwise. A newly received left word is not visible until the right word of the same frame is complete.
- R9: No valid strobe is produced until a left word has been captured after reset and after the first frame-clock transition, so a lone right half-frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame (left/right) clock |
| sdata_i | input | N_LANES | Serial data, one bit per lane |
| fmt_reg_i | input | 3 | Format code from a register |
| fmt_pin_i | input | 3 | Format code from strap pins |
| left_o | output | N_LANES*24 | Left samples, lane k at bits [24k+23:24k] |
| right_o | output | N_LANES*24 | Right samples, lane k at bits [24k+23:24k] |
| valid_o | output | 1 | One-cycle strobe when a new frame is published |

## Verification
Each format is driven with words chosen to tell its alignment apart. Full-scale positive and negative values and single-LSB values check the bit order and sign. Half-frames longer than the word are padded with ones, so a receiver that reads from the wrong end of the half-frame returns a visibly wrong word. Half-frames of exactly the minimum length exercise the boundary case in which a word ends on the frame-clock transition. The three lanes carry different data (the true word, its complement and an XOR pattern), so crossed or shared lanes show up. Pin-only, register-only and mixed format codes, including codes with bit 2 set, separate the OR decode from a single source. Directed sequences then send a lone left half-frame, a lone right half-frame after reset, and a reset in the middle of a stream, which separate hold-until-right and start-up behaviour from plain capture.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned LEN_W    = 5;
  localparam int unsigned SHORT_A  = 16;
  localparam int unsigned SHORT_B  = 20;

  typedef enum logic [1:0] {
    ALN_LSB = 2'd0,
    ALN_MSB = 2'd1,
    ALN_I2S = 2'd2
  } align_e;

  typedef struct packed {
    align_e           align;
    logic [LEN_W-1:0] wlen;
  } fmt_cfg_t;

  // Bit 2 takes priority: any code with it set is full-width right-aligned.
  function automatic fmt_cfg_t fmt_decode(input logic [2:0] code);
    fmt_cfg_t c;
    if (code[2]) begin
      c.align = ALN_LSB;
      c.wlen  = LEN_W'(SAMPLE_W);
    end else begin
      case (code[1:0])
        2'b00:   begin c.align = ALN_LSB; c.wlen = LEN_W'(SHORT_A);  end
        2'b01:   begin c.align = ALN_LSB; c.wlen = LEN_W'(SHORT_B);  end
        2'b10:   begin c.align = ALN_MSB; c.wlen = LEN_W'(SAMPLE_W); end
        default: begin c.align = ALN_I2S; c.wlen = LEN_W'(SAMPLE_W); end
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/pcmrx_sync.sv
module pcmrx_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out,
  output logic [WIDTH-1:0] prev_out
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [WIDTH-1:0] stg_q [DEPTH];
  logic [WIDTH-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = async_in;
    for (int i = 1; i < DEPTH; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign sync_out = stg_q[STAGES-1];
  assign prev_out = stg_q[STAGES];

endmodule

// File: rtl/pcmrx_framer.sv
module pcmrx_framer
  import pcmrx_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             lrck_s,
  input  logic [2:0]       fmt_code,
  output logic             cap_left_o,
  output logic             cap_right_o,
  output logic             commit_o,
  output logic             use_prev_o,
  output logic [LEN_W-1:0] wlen_o,
  output logic             valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] MSB_LAST = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] I2S_LAST = CNT_W'(SAMPLE_W + 1);

  fmt_cfg_t         cfg;
  logic             lr_prev_q, lr_prev_d;
  logic             primed_q, primed_d;
  logic             locked_q, locked_d;
  logic             left_seen_q, left_seen_d;
  logic             valid_q, valid_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, cnt_new;
  logic             edge_hit, cap_hit, half_lvl, is_left;
  logic             cap_left, cap_right, commit, use_prev;

  always_comb begin
    cfg      = fmt_decode(fmt_code);
    edge_hit = primed_q && (lrck_s != lr_prev_q);
    cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    cnt_new  = edge_hit ? CNT_W'(1) : cnt_inc;

    cap_hit  = 1'b0;
    half_lvl = lrck_s;
    use_prev = 1'b0;
    unique case (cfg.align)
      ALN_LSB: begin
        cap_hit  = locked_q && edge_hit;
        half_lvl = lr_prev_q;
        use_prev = 1'b1;
      end
      ALN_MSB: begin
        cap_hit = locked_q && (cnt_new == MSB_LAST);
      end
      default: begin
        if (edge_hit) begin
          cap_hit  = locked_q && (cnt_q == MSB_LAST);
          half_lvl = lr_prev_q;
        end else begin
          cap_hit = locked_q && (cnt_new == I2S_LAST);
        end
      end
    endcase

    is_left   = (cfg.align == ALN_I2S) ? ~half_lvl : half_lvl;
    cap_left  = bit_tick && cap_hit && is_left;
    cap_right = bit_tick && cap_hit && !is_left;
    commit    = cap_right && left_seen_q;
  end

  always_comb begin
    lr_prev_d   = lr_prev_q;
    primed_d    = primed_q;
    locked_d    = locked_q;
    cnt_d       = cnt_q;
    if (bit_tick) begin
      lr_prev_d = lrck_s;
      primed_d  = 1'b1;
      locked_d  = locked_q | edge_hit;
      cnt_d     = cnt_new;
    end
    left_seen_d = left_seen_q | cap_left;
    valid_d     = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q   <= 1'b0;
      primed_q    <= 1'b0;
      locked_q    <= 1'b0;
      left_seen_q <= 1'b0;
      valid_q     <= 1'b0;
      cnt_q       <= '0;
    end else begin
      lr_prev_q   <= lr_prev_d;
      primed_q    <= primed_d;
      locked_q    <= locked_d;
      left_seen_q <= left_seen_d;
      valid_q     <= valid_d;
      cnt_q       <= cnt_d;
    end
  end

  assign cap_left_o  = cap_left;
  assign cap_right_o = cap_right;
  assign commit_o    = commit;
  assign use_prev_o  = use_prev;
  assign wlen_o      = cfg.wlen;
  assign valid_o     = valid_q;

endmodule

// File: rtl/pcmrx_lane.sv
module pcmrx_lane
  import pcmrx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                sdata_s,
  input  logic                cap_left,
  input  logic                commit,
  input  logic                use_prev,
  input  logic [LEN_W-1:0]    wlen,
  output logic [SAMPLE_W-1:0] left_q_o,
  output logic [SAMPLE_W-1:0] right_q_o
);

  logic [SAMPLE_W-1:0] shreg_q, shreg_d, shreg_sh;
  logic [SAMPLE_W-1:0] hold_q, hold_d;
  logic [SAMPLE_W-1:0] left_q, left_d, right_q, right_d;
  logic [SAMPLE_W-1:0] src, aligned;
  logic [LEN_W-1:0]    pad;

  always_comb begin
    shreg_sh = {shreg_q[SAMPLE_W-2:0], sdata_s};
    src      = use_prev ? shreg_q : shreg_sh;
    pad      = LEN_W'(SAMPLE_W) - wlen;
    aligned  = src << pad;

    shreg_d  = bit_tick ? shreg_sh : shreg_q;
    hold_d   = cap_left ? aligned : hold_q;
    left_d   = commit ? hold_q : left_q;
    right_d  = commit ? aligned : right_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      hold_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      shreg_q <= shreg_d;
      hold_q  <= hold_d;
      left_q  <= left_d;
      right_q <= right_d;
    end
  end

  assign left_q_o  = left_q;
  assign right_q_o = right_q;

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcmrx_pkg::*;
#(
  parameter int unsigned N_LANES     = 3,
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bclk_i,
  input  logic                          lrclk_i,
  input  logic [N_LANES-1:0]            sdata_i,
  input  logic [2:0]                    fmt_reg_i,
  input  logic [2:0]                    fmt_pin_i,
  output logic [N_LANES*SAMPLE_W-1:0]   left_o,
  output logic [N_LANES*SAMPLE_W-1:0]   right_o,
  output logic                          valid_o
);

  localparam int unsigned SYN_W = N_LANES + 2;
  localparam int unsigned IDX_B = 0;
  localparam int unsigned IDX_L = 1;

  logic             rst_meta_q, rst_int_q;
  logic [SYN_W-1:0] syn_now, syn_prev;
  logic             bit_tick, lrck_s;
  logic [2:0]       fmt_code;
  logic             cap_left, cap_right, commit, use_prev;
  logic [LEN_W-1:0] wlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_q  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_q  <= rst_meta_q;
    end
  end

  pcmrx_sync #(
    .WIDTH  (SYN_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_q),
    .async_in ({sdata_i, lrclk_i, bclk_i}),
    .sync_out (syn_now),
    .prev_out (syn_prev)
  );

  assign bit_tick = syn_now[IDX_B] & ~syn_prev[IDX_B];
  assign lrck_s   = syn_now[IDX_L];
  assign fmt_code = fmt_reg_i | fmt_pin_i;

  pcmrx_framer #(
    .CNT_W (CNT_W)
  ) u_framer (
    .clk         (clk),
    .rst_n       (rst_int_q),
    .bit_tick    (bit_tick),
    .lrck_s      (lrck_s),
    .fmt_code    (fmt_code),
    .cap_left_o  (cap_left),
    .cap_right_o (cap_right),
    .commit_o    (commit),
    .use_prev_o  (use_prev),
    .wlen_o      (wlen),
    .valid_o     (valid_o)
  );

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic [SAMPLE_W-1:0] lane_l, lane_r;

    pcmrx_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_int_q),
      .bit_tick  (bit_tick),
      .sdata_s   (syn_now[2+k]),
      .cap_left  (cap_left),
      .commit    (commit),
      .use_prev  (use_prev),
      .wlen      (wlen),
      .left_q_o  (lane_l),
      .right_q_o (lane_r)
    );

    assign left_o[k*SAMPLE_W +: SAMPLE_W]  = lane_l;
    assign right_o[k*SAMPLE_W +: SAMPLE_W] = lane_r;
  end

endmodule

// File: rtl/pcmrx_chk.sv
module pcmrx_chk #(
  parameter int unsigned OUT_W = 72
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             cap_left,
  input logic             cap_right,
  input logic             valid_o,
  input logic [OUT_W-1:0] left_o,
  input logic [OUT_W-1:0] right_o
);

  logic seen_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_left_q <= 1'b0;
    else        seen_left_q <= seen_left_q | cap_left;
  end

  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (left_o == '0 && right_o == '0 && !valid_o)
        else $error("a_r1_reset_clear");
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  a_r3_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(bit_tick));

  a_r8_after_right: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(cap_right));

  a_r9_left_first: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> seen_left_q);

  a_r8_capture_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_left && cap_right));

endmodule

bind pcm_serial_rx pcmrx_chk #(
  .OUT_W (N_LANES * pcmrx_pkg::SAMPLE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .cap_left  (cap_left),
  .cap_right (cap_right),
  .valid_o   (valid_o),
  .left_o    (left_o),
  .right_o   (right_o)
);

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;

  localparam int NL = 3;
  localparam int SW = 24;
  localparam int OW = NL * SW;
  localparam int BH = 8;
  localparam int NV = 11;

  typedef struct packed {
    logic [2:0]  freg;
    logic [2:0]  fpin;
    logic [5:0]  hb;
    logic [23:0] l;
    logic [23:0] r;
    logic [23:0] el;
    logic [23:0] er;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{3'b000, 3'b000, 6'd16, 24'h008001, 24'h007FFE, 24'h800100, 24'h7FFE00},
    '{3'b000, 3'b000, 6'd32, 24'hAB1234, 24'h00FFFF, 24'h123400, 24'hFFFF00},
    '{3'b001, 3'b000, 6'd20, 24'h080000, 24'h012345, 24'h800000, 24'h123450},
    '{3'b000, 3'b010, 6'd24, 24'hA5C3E1, 24'h000001, 24'hA5C3E1, 24'h000001},
    '{3'b010, 3'b001, 6'd32, 24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h800000},
    '{3'b100, 3'b000, 6'd32, 24'h123456, 24'hFEDCBA, 24'h123456, 24'hFEDCBA},
    '{3'b001, 3'b010, 6'd24, 24'h000100, 24'hFFFFFE, 24'h000100, 24'hFFFFFE},
    '{3'b110, 3'b000, 6'd32, 24'h654321, 24'h0F0F0F, 24'h654321, 24'h0F0F0F},
    '{3'b000, 3'b101, 6'd24, 24'h800001, 24'h7FFFFE, 24'h800001, 24'h7FFFFE},
    '{3'b010, 3'b000, 6'd32, 24'hBEEF00, 24'h123400, 24'hBEEF00, 24'h123400},
    '{3'b001, 3'b000, 6'd32, 24'h07FFFF, 24'h0FFFFF, 24'h7FFFF0, 24'hFFFFF0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bclk = 1'b0;
  logic          lrck = 1'b0;
  logic [NL-1:0] sdata = '0;
  logic [2:0]    fmt_reg = '0;
  logic [2:0]    fmt_pin = '0;
  logic [OW-1:0] left_o, right_o;
  logic          valid_o;

  int   n_chk = 0;
  int   n_bad = 0;
  int   vcnt  = 0;
  bit   done  = 1'b0;
  logic [NL-1:0] pend = '1;

  always #2 clk = ~clk;

  pcm_serial_rx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_i    (bclk),
    .lrclk_i   (lrck),
    .sdata_i   (sdata),
    .fmt_reg_i (fmt_reg),
    .fmt_pin_i (fmt_pin),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

  always @(negedge clk) if (valid_o) vcnt++;

  task automatic chk(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // 0 right-aligned, 1 left-aligned, 2 one-bit delayed (R2)
  function automatic int align_of(input logic [2:0] c);
    if (c[2]) return 0;
    if (c[1:0] == 2'b10) return 1;
    if (c[1:0] == 2'b11) return 2;
    return 0;
  endfunction

  function automatic int wlen_of(input logic [2:0] c);
    if (c[2]) return 24;
    if (c[1:0] == 2'b00) return 16;
    if (c[1:0] == 2'b01) return 20;
    return 24;
  endfunction

  function automatic logic [23:0] exp_word(input logic [2:0] c, input logic [23:0] raw);
    logic [23:0] t;
    t = raw << (24 - wlen_of(c));
    return t;
  endfunction

  function automatic logic layout_bit(input logic [2:0] c, input int hb, input int p,
                                      input logic [23:0] raw);
    int wl;
    wl = wlen_of(c);
    if (align_of(c) == 0) begin
      if (p >= hb - wl) return raw[hb-1-p];
      return 1'b1;
    end
    if (p < 24) return raw[23-p];
    return 1'b1;
  endfunction

  function automatic logic [23:0] lane_raw(input int k, input logic [23:0] w);
    if (k == 0) return w;
    if (k == 1) return ~w;
    return w ^ 24'h3C3C3C;
  endfunction

  task automatic bit_out(input logic lr, input logic [NL-1:0] d);
    bclk = 1'b0; lrck = lr; sdata = d;
    repeat (BH) @(negedge clk);
    bclk = 1'b1;
    repeat (BH) @(negedge clk);
  endtask

  task automatic send_half(input logic [2:0] c, input int hb, input bit right,
                           input logic [23:0] w);
    logic          left_lvl;
    logic [NL-1:0] d;
    left_lvl = (align_of(c) == 2) ? 1'b0 : 1'b1;
    for (int p = 0; p < hb; p++) begin
      for (int k = 0; k < NL; k++) d[k] = layout_bit(c, hb, p, lane_raw(k, w));
      if (align_of(c) == 2) begin
        bit_out(right ? ~left_lvl : left_lvl, pend);
        pend = d;
      end else begin
        bit_out(right ? ~left_lvl : left_lvl, d);
      end
    end
  endtask

  task automatic send_frame(input logic [2:0] c, input int hb,
                            input logic [23:0] l, input logic [23:0] r);
    send_half(c, hb, 1'b0, l);
    send_half(c, hb, 1'b1, r);
  endtask

  task automatic close_frame(input logic [2:0] c);
    logic left_lvl;
    left_lvl = (align_of(c) == 2) ? 1'b0 : 1'b1;
    bit_out(left_lvl, (align_of(c) == 2) ? pend : '1);
  endtask

  function automatic logic [OW-1:0] exp_bus(input logic [2:0] c, input logic [23:0] w);
    logic [OW-1:0] b;
    for (int k = 0; k < NL; k++) b[k*SW +: SW] = exp_word(c, lane_raw(k, w));
    return b;
  endfunction

  function automatic string mode_tag(input logic [2:0] c);
    if (align_of(c) == 1) return "R5 R7";
    if (align_of(c) == 2) return "R6";
    return "R4 R7";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]    c;
    logic [OW-1:0] xl, xr;
    int            expv;

    repeat (5) @(negedge clk);
    chk("R1 reset outputs", {left_o ^ right_o, 1'b0} | {left_o, 1'b0}, '0);
    chk("R1 reset valid", OW'(valid_o), '0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 idle after release", left_o | right_o, '0);

    for (int i = 0; i < NV; i++) begin
      fmt_reg = VEC[i].freg;
      fmt_pin = VEC[i].fpin;
      c = VEC[i].freg | VEC[i].fpin;
      send_frame(c, int'(VEC[i].hb), VEC[i].l, VEC[i].r);
      send_frame(c, int'(VEC[i].hb), VEC[i].l, VEC[i].r);
      vcnt = 0;
      send_frame(c, int'(VEC[i].hb), VEC[i].l, VEC[i].r);
      close_frame(c);
      repeat (40) @(negedge clk);
      xl = exp_bus(c, VEC[i].l);
      xr = exp_bus(c, VEC[i].r);
      xl[SW-1:0] = VEC[i].el;
      xr[SW-1:0] = VEC[i].er;
      chk($sformatf("R2 R3 %s left vec %0d", mode_tag(c), i), left_o, xl);
      chk($sformatf("R2 R3 %s right vec %0d", mode_tag(c), i), right_o, xr);
      expv = (align_of(c) == 0 || (align_of(c) == 2 && VEC[i].hb < 25)) ? 2 : 1;
      chk($sformatf("R8 valid count vec %0d", i), OW'(vcnt), OW'(expv));
    end

    // R8: a new left half alone must not reach the outputs
    fmt_reg = 3'b010; fmt_pin = 3'b000; c = 3'b010;
    send_frame(c, 32, 24'h111111, 24'h222222);
    send_frame(c, 32, 24'h111111, 24'h222222);
    repeat (40) @(negedge clk);
    vcnt = 0;
    send_half(c, 32, 1'b0, 24'h333333);
    repeat (40) @(negedge clk);
    chk("R8 left held", left_o, exp_bus(c, 24'h111111));
    chk("R8 right held", right_o, exp_bus(c, 24'h222222));
    chk("R8 no strobe on left half", OW'(vcnt), '0);
    send_half(c, 32, 1'b1, 24'h444444);
    repeat (40) @(negedge clk);
    chk("R8 left published", left_o, exp_bus(c, 24'h333333));
    chk("R8 right published", right_o, exp_bus(c, 24'h444444));
    chk("R8 one strobe", OW'(vcnt), OW'(1));

    // R1: reset in the middle of a stream
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mid-stream reset", left_o | right_o, '0);
    chk("R1 mid-stream valid", OW'(valid_o), '0);

    // R9: lone right half after reset is ignored
    lrck = 1'b1; bclk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    vcnt = 0;
    for (int p = 0; p < 3; p++) bit_out(1'b1, '1);
    send_half(c, 32, 1'b1, 24'h5A5A5A);
    repeat (40) @(negedge clk);
    chk("R9 no strobe for lone right", OW'(vcnt), '0);
    chk("R9 outputs still zero", left_o | right_o, '0);
    send_frame(c, 32, 24'h765432, 24'h89ABCD);
    repeat (40) @(negedge clk);
    chk("R9 first full frame strobe", OW'(vcnt), OW'(1));
    chk("R9 first left", left_o, exp_bus(c, 24'h765432));
    chk("R9 first right", right_o, exp_bus(c, 24'h89ABCD));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule